// File: doc/BRIEF.md
# DMA Channel Interrupt Cause Unit

This block gathers the single-cycle event pulses raised by a DMA transfer channel and its companion event channel. Each event sets its own bit in a sticky status register. Software reads that register, acknowledges bits by writing ones to a clear register, and chooses which causes may interrupt it through an enable register. The AND of status and enable is the live cause. It drives one of two outputs. In wired mode this is a level line that stays high while any live cause remains. In message mode it is a one-cycle pulse that a downstream message generator turns into a write.

A pending-work input keeps the completion cause raised. While the channel still holds unprocessed events, bit 0 cannot be cleared, so the interrupt keeps coming back. In message mode, a clear write that leaves a live cause standing sends a fresh pulse. A separate output flags any live cause in the error group.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset the status register and the enable register read 0, interrupt control reads 1 (wired mode), and irq_level, irq_pulse and irq_err are low.
- R2: Each event pulse sets its own status bit, and the bit stays set until it is cleared. The bits are: block done 0, event-write error 1, descriptor-read error 9, data-read error 10, data-write error 11, bad descriptor 14. Status is read at offset 0x100.
- R3: A channel-reset-done pulse sets status bit 8.
- R4: A write to offset 0x108 clears each status bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged. A read of 0x108 returns 0.
- R5: An event that arrives in the same cycle as a clear of its own bit wins, so the bit stays set.
- R6: The enable register at offset 0x110 holds only the implemented bits (mask 0x4F03). Status bits outside that mask always read 0.
- R7: In wired mode (interrupt control bits [3:0] equal 1), irq_level is high exactly when status AND enable is nonzero, and irq_pulse stays low.
- R8: In message mode (any other value of bits [3:0]), irq_level stays low and irq_pulse is high for one cycle when status AND enable changes from zero to nonzero.
- R9: In message mode, a clear write that removes at least one live cause bit, while a live cause remains afterwards, produces one more irq_pulse in the cycle after the write.
- R10: While work_pending is high, status bit 0 is set every cycle and a clear of bit 0 does not take effect. Once work_pending is low, the clear works.
- R11: Writes to the status offset 0x100 and to unmapped offsets change nothing, and unmapped offsets read 0. Interrupt control at offset 0x004 stores only bits [3:0], and its upper bits read 0.
- R12: irq_err is high in either mode exactly when status AND enable has a bit set in the error group (mask 0x4E02).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_blk_done | input | 1 | Block-completion event pulse |
| ev_evt_wr_err | input | 1 | Event-write response error pulse |
| ev_desc_rd_err | input | 1 | Descriptor-read response error pulse |
| ev_data_rd_err | input | 1 | Data-read error pulse |
| ev_data_wr_err | input | 1 | Data-write error pulse |
| ev_bad_desc | input | 1 | Invalid-descriptor pulse |
| ev_chan_rst_done | input | 1 | Channel-reset-complete pulse |
| work_pending | input | 1 | High while unprocessed events remain |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| irq_level | output | 1 | Wired-mode level interrupt |
| irq_pulse | output | 1 | Message-mode single-cycle request |
| irq_err | output | 1 | Live cause in the error group |

## Verification
An event pulse or register write presented before clock edge k updates the registers at edge k. irq_level, irq_err and reg_rdata follow from those registers with no further delay, so they are due in the cycle that begins at edge k. irq_pulse is also due in that cycle, because it compares the new live cause with the one registered from before edge k. The retrigger pulse of R9 is due in the cycle after the clear write. The bench drives every input just after a falling edge, waits for one rising edge, and compares at the next falling edge against a model stepped once per cycle. Register reads are taken combinationally in the half cycle before the next edge.

// File: rtl/irqu_pkg.sv
package irqu_pkg;
  localparam int STAT_W = 16;
  typedef logic [STAT_W-1:0] stat_t;

  // bit positions software decodes
  localparam int B_BLK_DONE    = 0;
  localparam int B_EVT_WR_ERR  = 1;
  localparam int B_RST_DONE    = 8;
  localparam int B_DESC_RD_ERR = 9;
  localparam int B_DATA_RD_ERR = 10;
  localparam int B_DATA_WR_ERR = 11;
  localparam int B_BAD_DESC    = 14;

  localparam logic [3:0] MODE_WIRED = 4'd1;

  localparam stat_t ERR_MASK = (stat_t'(1) << B_EVT_WR_ERR)  | (stat_t'(1) << B_DESC_RD_ERR) |
                               (stat_t'(1) << B_DATA_RD_ERR) | (stat_t'(1) << B_DATA_WR_ERR) |
                               (stat_t'(1) << B_BAD_DESC);
  localparam stat_t IMPL_MASK = ERR_MASK | (stat_t'(1) << B_BLK_DONE) | (stat_t'(1) << B_RST_DONE);

  // set has priority over clear
  function automatic stat_t sticky_next(stat_t cur, stat_t set, stat_t clr);
    return ((cur & ~clr) | set) & IMPL_MASK;
  endfunction

  // message request: first live cause, or a clear that left work standing
  function automatic logic fire_msg(logic any_now, logic any_prev, logic clr_hit_prev);
    return any_now && (!any_prev || clr_hit_prev);
  endfunction
endpackage

// File: rtl/irqu_status_reg.sv
module irqu_status_reg
  import irqu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t set_vec,
  input  stat_t clr_vec,
  output stat_t stat_q
);
  stat_t nxt;
  assign nxt = sticky_next(stat_q, set_vec, clr_vec);

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_flop
      always_ff @(posedge clk) begin
        if (!rst_n) stat_q[i] <= 1'b0;
        else        stat_q[i] <= nxt[i];
      end
    end else begin : g_tie
      assign stat_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irqu_regif.sv
module irqu_regif
  import irqu_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int OFF_CTRL  = 'h004,
  parameter int OFF_STAT  = 'h100,
  parameter int OFF_CLR   = 'h108,
  parameter int OFF_EN    = 'h110
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  stat_t             stat_q,
  output stat_t             clr_vec,
  output stat_t             en_q,
  output logic [3:0]        mode_q,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);

  logic hit_ctrl, hit_clr, hit_en;
  assign hit_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign hit_clr  = reg_wr && (reg_addr == A_CLR);
  assign hit_en   = reg_wr && (reg_addr == A_EN);

  assign clr_vec = hit_clr ? reg_wdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= MODE_WIRED;
    end else begin
      if (hit_en)   en_q   <= reg_wdata[STAT_W-1:0] & IMPL_MASK;
      if (hit_ctrl) mode_q <= reg_wdata[3:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_STAT)      reg_rdata[STAT_W-1:0] = stat_q;
    else if (reg_addr == A_EN)   reg_rdata[STAT_W-1:0] = en_q;
    else if (reg_addr == A_CTRL) reg_rdata[3:0]        = mode_q;
  end
endmodule

// File: rtl/irqu_deliver.sv
module irqu_deliver
  import irqu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  stat_t      stat_q,
  input  stat_t      en_q,
  input  logic [3:0] mode_q,
  input  stat_t      clr_vec,
  output stat_t      cause,
  output logic       clr_hit_q,
  output logic       irq_level,
  output logic       irq_pulse,
  output logic       irq_err
);
  logic wired, any_now, any_q;

  assign cause   = stat_q & en_q;
  assign any_now = |cause;
  assign wired   = (mode_q == MODE_WIRED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      any_q     <= 1'b0;
      clr_hit_q <= 1'b0;
    end else begin
      any_q     <= any_now;
      clr_hit_q <= |(clr_vec & cause);
    end
  end

  assign irq_level = wired && any_now;
  assign irq_pulse = !wired && fire_msg(any_now, any_q, clr_hit_q);
  assign irq_err   = |(cause & ERR_MASK);
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
  import irqu_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int OFF_CTRL = 'h004,
  parameter int OFF_STAT = 'h100,
  parameter int OFF_CLR  = 'h108,
  parameter int OFF_EN   = 'h110
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_blk_done,
  input  logic              ev_evt_wr_err,
  input  logic              ev_desc_rd_err,
  input  logic              ev_data_rd_err,
  input  logic              ev_data_wr_err,
  input  logic              ev_bad_desc,
  input  logic              ev_chan_rst_done,
  input  logic              work_pending,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_level,
  output logic              irq_pulse,
  output logic              irq_err
);
  stat_t      set_vec, clr_vec, stat_q, en_q, cause;
  logic [3:0] mode_q;
  logic       clr_hit_q;

  // pending work keeps the completion cause raised
  always_comb begin
    set_vec                = '0;
    set_vec[B_BLK_DONE]    = ev_blk_done | work_pending;
    set_vec[B_EVT_WR_ERR]  = ev_evt_wr_err;
    set_vec[B_RST_DONE]    = ev_chan_rst_done;
    set_vec[B_DESC_RD_ERR] = ev_desc_rd_err;
    set_vec[B_DATA_RD_ERR] = ev_data_rd_err;
    set_vec[B_DATA_WR_ERR] = ev_data_wr_err;
    set_vec[B_BAD_DESC]    = ev_bad_desc;
  end

  irqu_regif #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_CTRL(OFF_CTRL),
    .OFF_STAT(OFF_STAT), .OFF_CLR(OFF_CLR), .OFF_EN(OFF_EN)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .stat_q(stat_q), .clr_vec(clr_vec),
    .en_q(en_q), .mode_q(mode_q), .reg_rdata(reg_rdata)
  );

  irqu_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .stat_q(stat_q)
  );

  irqu_deliver u_dlv (
    .clk(clk), .rst_n(rst_n), .stat_q(stat_q), .en_q(en_q), .mode_q(mode_q),
    .clr_vec(clr_vec), .cause(cause), .clr_hit_q(clr_hit_q),
    .irq_level(irq_level), .irq_pulse(irq_pulse), .irq_err(irq_err)
  );
endmodule

// File: rtl/dma_irq_unit_chk.sv
module dma_irq_unit_chk
  import irqu_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int OFF_STAT = 'h100,
  parameter int OFF_CLR  = 'h108
)(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              ev_blk_done,
  input logic              work_pending,
  input stat_t             set_vec,
  input stat_t             clr_vec,
  input stat_t             stat_q,
  input logic              irq_level,
  input logic              irq_pulse
);
  logic clr_wr, stat_wr;
  assign clr_wr  = reg_wr && (reg_addr == ADDR_W'(OFF_CLR));
  assign stat_wr = reg_wr && (reg_addr == ADDR_W'(OFF_STAT));

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec != '0) && (set_vec == '0)) |=> ((stat_q & $past(clr_vec)) == '0));

  a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_blk_done |=> stat_q[B_BLK_DONE]);

  a_r7_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_level && irq_pulse));

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && !clr_wr) |=> !irq_pulse);

  a_r10_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    work_pending |=> stat_q[B_BLK_DONE]);

  a_r11_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && (set_vec == '0)) |=> $stable(stat_q));
endmodule

bind dma_irq_unit dma_irq_unit_chk #(
  .ADDR_W(ADDR_W), .OFF_STAT(OFF_STAT), .OFF_CLR(OFF_CLR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .ev_blk_done(ev_blk_done), .work_pending(work_pending),
  .set_vec(set_vec), .clr_vec(clr_vec), .stat_q(stat_q),
  .irq_level(irq_level), .irq_pulse(irq_pulse)
);

// File: tb/dma_irq_unit_test.sv
module dma_irq_unit_test;
  localparam logic [15:0] KEEP = 16'h4F03;
  localparam logic [15:0] ERRS = 16'h4E02;
  localparam logic [11:0] A_CTRL = 12'h004, A_STAT = 12'h100, A_CLR = 12'h108, A_EN = 12'h110, A_NONE = 12'h200;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic ev_blk_done, ev_evt_wr_err, ev_desc_rd_err, ev_data_rd_err, ev_data_wr_err, ev_bad_desc;
  logic ev_chan_rst_done, work_pending, reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic irq_level, irq_pulse, irq_err;

  dma_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .ev_blk_done(ev_blk_done), .ev_evt_wr_err(ev_evt_wr_err),
    .ev_desc_rd_err(ev_desc_rd_err), .ev_data_rd_err(ev_data_rd_err),
    .ev_data_wr_err(ev_data_wr_err), .ev_bad_desc(ev_bad_desc),
    .ev_chan_rst_done(ev_chan_rst_done), .work_pending(work_pending),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_level(irq_level), .irq_pulse(irq_pulse), .irq_err(irq_err)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] m_st, m_en;
  logic [3:0]  m_mode;
  logic        m_anyq, m_hitq;

  // ev: [0] done [1] evwr [2] descrd [3] datard [4] datawr [5] baddesc [6] rstdone [7] pending
  function automatic logic [15:0] ev_bits(logic [7:0] ev);
    logic [15:0] r = '0;
    r[0] = ev[0] | ev[7]; r[1] = ev[1]; r[9] = ev[2]; r[10] = ev[3];
    r[11] = ev[4]; r[14] = ev[5]; r[8] = ev[6];
    return r;
  endfunction

  function automatic logic exp_pulse(logic [15:0] c);
    return (m_mode != 4'd1) && (c != 0) && (!m_anyq || m_hitq);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cycle(logic [7:0] ev, logic wr, logic [11:0] a, logic [31:0] d);
    logic [15:0] clr, c_old, c;
    {work_pending, ev_chan_rst_done, ev_bad_desc, ev_data_wr_err, ev_data_rd_err,
     ev_desc_rd_err, ev_evt_wr_err, ev_blk_done} = ev;
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    clr    = (wr && a == A_CLR) ? d[15:0] : 16'h0;
    c_old  = m_st & m_en;
    m_anyq = |c_old;
    m_hitq = |(clr & c_old);
    m_st   = ((m_st & ~clr) | ev_bits(ev)) & KEEP;
    if (wr && a == A_EN)   m_en = d[15:0] & KEEP;
    if (wr && a == A_CTRL) m_mode = d[3:0];
    @(posedge clk); @(negedge clk);
    {work_pending, ev_chan_rst_done, ev_bad_desc, ev_data_wr_err, ev_data_rd_err,
     ev_desc_rd_err, ev_evt_wr_err, ev_blk_done} = 8'h0;
    reg_wr = 1'b0;
    c = m_st & m_en;
    check("R7 irq_level", {31'h0, irq_level}, {31'h0, (m_mode == 4'd1) && (c != 0)});
    check("R8 irq_pulse", {31'h0, irq_pulse}, {31'h0, exp_pulse(c)});
    check("R12 irq_err",  {31'h0, irq_err},   {31'h0, |(c & ERRS)});
  endtask

  task automatic expect_reg(string tag, logic [11:0] a, logic [31:0] exp);
    reg_wr = 1'b0; reg_addr = a;
    #1 check(tag, reg_rdata, exp);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    cycle(8'h0, 1'b1, a, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    {work_pending, ev_chan_rst_done, ev_bad_desc, ev_data_wr_err, ev_data_rd_err,
     ev_desc_rd_err, ev_evt_wr_err, ev_blk_done} = 8'h0;
    m_st = 0; m_en = 0; m_mode = 4'd1; m_anyq = 0; m_hitq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_reg("R1 status", A_STAT, 0);
    expect_reg("R1 enable", A_EN, 0);
    expect_reg("R1 ctrl", A_CTRL, 1);
    check("R1 outputs", {29'h0, irq_level, irq_pulse, irq_err}, 0);

    // R6 enable mask
    wr(A_EN, 32'hFFFF_FFFF);
    expect_reg("R6 enable mask", A_EN, 32'h4F03);

    // R2 / R3 each source alone, then R4 clear
    for (int k = 0; k < 7; k++) begin
      logic [15:0] b;
      b = ev_bits(8'(1 << k));
      cycle(8'(1 << k), 1'b0, A_STAT, 0);
      expect_reg(k == 6 ? "R3 reset done bit" : "R2 event bit", A_STAT, {16'h0, b});
      cycle(8'h0, 1'b0, A_STAT, 0);
      expect_reg("R2 sticky", A_STAT, {16'h0, b});
      check("R7 level on", {31'h0, irq_level}, 1);
      wr(A_CLR, {16'h0, b});
      expect_reg("R4 cleared", A_STAT, 0);
    end

    // R4 partial and zero clear
    cycle(8'h05, 1'b0, A_STAT, 0);
    wr(A_CLR, 32'h0000_0001);
    expect_reg("R4 partial clear", A_STAT, 32'h0200);
    wr(A_CLR, 32'h0);
    expect_reg("R4 zero write", A_STAT, 32'h0200);
    expect_reg("R4 clear reads zero", A_CLR, 0);

    // R5 event beats clear
    cycle(8'h08, 1'b0, A_STAT, 0);
    cycle(8'h08, 1'b1, A_CLR, 32'h0000_0400);
    expect_reg("R5 set wins", A_STAT, 32'h0600);

    // R11 read-only status, unmapped, ctrl width
    wr(A_STAT, 32'h0);
    expect_reg("R11 status write ignored", A_STAT, 32'h0600);
    wr(A_NONE, 32'hFFFF_FFFF);
    expect_reg("R11 unmapped reads zero", A_NONE, 0);
    wr(A_CTRL, 32'hFFFF_FFF1);
    expect_reg("R11 ctrl low nibble", A_CTRL, 1);
    wr(A_CLR, 32'hFFFF);

    // R7 / R12 masking
    wr(A_EN, 32'h0001);
    cycle(8'h04, 1'b0, A_STAT, 0);
    check("R7 masked level", {31'h0, irq_level}, 0);
    check("R12 masked err", {31'h0, irq_err}, 0);
    wr(A_EN, {16'h0, ERRS});
    check("R12 err enabled", {31'h0, irq_err}, 1);
    wr(A_CLR, 32'hFFFF);
    check("R12 err cleared", {31'h0, irq_err}, 0);

    // R8 message mode
    wr(A_EN, 32'h4F03);
    wr(A_CTRL, 32'h0);
    cycle(8'h01, 1'b0, A_STAT, 0);
    check("R8 pulse rises", {31'h0, irq_pulse}, 1);
    check("R8 no level", {31'h0, irq_level}, 0);
    cycle(8'h01, 1'b0, A_STAT, 0);
    check("R8 no repeat", {31'h0, irq_pulse}, 0);

    // R9 retrigger
    cycle(8'h02, 1'b0, A_STAT, 0);
    wr(A_CLR, 32'h0001);
    check("R9 retrigger pulse", {31'h0, irq_pulse}, 1);
    cycle(8'h0, 1'b0, A_STAT, 0);
    check("R9 single retrigger", {31'h0, irq_pulse}, 0);
    wr(A_CLR, 32'h0002);
    check("R9 no pulse when empty", {31'h0, irq_pulse}, 0);

    // R10 pending work
    cycle(8'h80, 1'b0, A_STAT, 0);
    check("R10 pending raises", {31'h0, irq_pulse}, 1);
    cycle(8'h80, 1'b1, A_CLR, 32'h0001);
    expect_reg("R10 clear blocked", A_STAT, 32'h0001);
    check("R10 re-raise pulse", {31'h0, irq_pulse}, 1);
    wr(A_CLR, 32'h0001);
    expect_reg("R10 clear after pending", A_STAT, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ev;
      logic       w;
      logic [11:0] a;
      logic [31:0] d;
      for (int k = 0; k < 7; k++) ev[k] = ($urandom % 10) == 0;
      ev[7] = ($urandom % 6) == 0;
      w = ($urandom % 3) == 0;
      case ($urandom % 5)
        0: a = A_STAT; 1: a = A_CLR; 2: a = A_EN; 3: a = A_CTRL; default: a = A_NONE;
      endcase
      d = $urandom;
      if (a == A_CTRL) d[3:0] = (($urandom % 3) == 0) ? 4'($urandom) : 4'($urandom % 2);
      cycle(ev, w, a, d);
      if (i % 4 == 0) expect_reg("R2 status model", A_STAT, {16'h0, m_st});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule